// File: doc/BRIEF.md
# Privileged State and Exception Return Controller

This block keeps the small set of privileged control registers a processor core needs to leave exception handlers and to gate interrupts. It holds a status word, a cause word, three return addresses (normal, error and debug), an exception base register and a hardware-register enable word. The core sends it one operation per clock on `op_i`: a register write or read selected by `sel_i`, a normal return, a debug return, an interrupt disable or enable, or a user-level read of a hardware register selected by `hw_idx_i`.

The controller returns the next program counter on a return, a user-mode flag, a link bit, an interrupt request and a reserved-instruction exception pulse. All updates take effect on the clock edge. Results of an operation (`rd_data_o`, `rd_valid_o`, `pc_o`, `pc_load_o`, `ri_exc_o`) appear one edge after the operation is presented. The interrupt request comes from a three-state machine: IRQ_IDLE moves to IRQ_RAISE ("arm") when the interrupt condition holds on the registered state; IRQ_RAISE drives a one-cycle request and clears the exception-code field of cause, then goes to IRQ_WAIT ("hold") while the condition persists or back to IRQ_IDLE ("drop") when it has gone; IRQ_WAIT returns to IRQ_IDLE ("release") once the condition is false.

Operation codes: 0 idle, 1 write, 2 read, 3 return, 4 debug return, 5 interrupt disable, 6 interrupt enable, 7 hardware read. Register selects: 0 status, 1 cause, 2 return address, 3 error return address, 4 debug return address, 5 exception base, 6 hardware enable. Status bits: 0 interrupt enable, 1 exception level, 2 error level, 4 user, 15:8 interrupt mask, 28 coprocessor-0 usable. Cause bits 15:8 are the pending field and 6:2 the exception code.

Top module: `priv_state_ctrl`

## Requirements
- R1: After reset, status reads 0x00000004, cause 0, all return addresses 0, exception base 0x80000000, hardware enable 0; user mode, link bit, interrupt request and `pc_load_o` are low. A read (op 2) returns the selected register on `rd_data_o` with `rd_valid_o` high one edge later.
- R2: A return (op 3) with the error-level bit set loads `pc_o` from the error return address and clears only error level.
- R3: A return (op 3) with error level clear loads `pc_o` from the return address and clears exception level.
- R4: A debug return (op 4) loads `pc_o` from the debug return address and leaves status unchanged.
- R5: After either return, `pc_load_o` is high for one cycle and the link bit reads 1.
- R6: `user_mode_o` is high only when exception level, error level and `debug_mode_i` are all low and the user bit is set.
- R7: One cycle after the registered state shows interrupt enable set, exception and error level clear, debug mode low and a non-zero AND of the status mask and cause pending fields, `irq_req_o` is high for exactly one cycle and the cause exception-code field is cleared.
- R8: A write (op 1) to cause changes only the bits in mask 0x00C00300.
- R9: A write to the exception base stores 0x80000000 OR (data AND 0x3FFFF000); a write to hardware enable keeps only bits 3:0.
- R10: Interrupt disable (op 5) returns the old status on `rd_data_o` and clears interrupt enable; interrupt enable (op 6) returns the old status and sets it.
- R11: A hardware read (op 7) of register k succeeds when user mode is low, or enable bit k is set, or the coprocessor-0 bit is set; otherwise `ri_exc_o` pulses for one cycle and `rd_valid_o` stays low.
- R12: Hardware register 0 returns exception base bits 9:0, register 1 the cache-line step parameter (32), register 2 `cycle_count_i`, register 3 the counter resolution parameter (2).
- R13: A write to status changes only the bits in the writable mask 0x1000FF17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code for this cycle |
| sel_i | input | 3 | Register select for write and read |
| wdata_i | input | 32 | Write data |
| hw_idx_i | input | 2 | Hardware register index for op 7 |
| debug_mode_i | input | 1 | Core is in debug mode |
| cycle_count_i | input | 32 | Cycle counter value for hardware register 2 |
| pc_o | output | 32 | Return target |
| pc_load_o | output | 1 | Pulse: `pc_o` is valid |
| rd_data_o | output | 32 | Read or old-status result |
| rd_valid_o | output | 1 | Pulse: `rd_data_o` updated |
| user_mode_o | output | 1 | Effective user mode |
| link_bit_o | output | 1 | Link state, set by returns |
| irq_req_o | output | 1 | External interrupt request pulse |
| ri_exc_o | output | 1 | Reserved-instruction exception pulse |

## Verification
A wrong status bit shows at once on `user_mode_o` and, one read later, on `rd_data_o`; the permission sweep crosses every combination of level bits, user bit, debug mode, enable bits and index, so a mis-wired term in the user-mode or permission logic turns a success into an exception or the reverse within one operation. A wrong interrupt-machine state shows as a missing pulse, a late pulse or a pulse that lasts two cycles, all caught in the two cycles after the pending bits are written. A wrong choice of return address shows on `pc_o` in the cycle after the return.

// File: rtl/priv_pkg.sv
`timescale 1ns/1ps
package priv_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_ERET  = 3'd3,
        OP_DERET = 3'd4,
        OP_DI    = 3'd5,
        OP_EI    = 3'd6,
        OP_RDHW  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CAUSE  = 3'd1,
        SEL_EPC    = 3'd2,
        SEL_ERREPC = 3'd3,
        SEL_DEPC   = 3'd4,
        SEL_EBASE  = 3'd5,
        SEL_HWRENA = 3'd6,
        SEL_NONE   = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_RAISE = 2'd1,
        IRQ_WAIT  = 2'd2
    } irq_state_e;

    localparam int ST_IE    = 0;
    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_UM    = 4;
    localparam int ST_IM_LO = 8;
    localparam int ST_CU0   = 28;
    localparam int CA_EC_LO = 2;
    localparam int CA_EC_W  = 5;
    localparam int CA_IP_LO = 8;
    localparam int PEND_W   = 8;

endpackage

// File: rtl/priv_regs.sv
`timescale 1ns/1ps
module priv_regs
    import priv_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          NUM_HWREG   = 4,
    parameter logic [31:0] STATUS_RST  = 32'h0000_0004,
    parameter logic [31:0] STATUS_MASK = 32'h1000_FF17,
    parameter logic [31:0] CAUSE_MASK  = 32'h00C0_0300,
    parameter logic [31:0] EBASE_FIXED = 32'h8000_0000,
    parameter logic [31:0] EBASE_MASK  = 32'h3FFF_F000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  op,
    input  sel_e                 sel,
    input  logic [DW-1:0]        wdata,
    input  logic                 ec_clear,
    output logic [DW-1:0]        status_q,
    output logic [DW-1:0]        cause_q,
    output logic [DW-1:0]        epc_q,
    output logic [DW-1:0]        errepc_q,
    output logic [DW-1:0]        depc_q,
    output logic [DW-1:0]        ebase_q,
    output logic [NUM_HWREG-1:0] hwrena_q,
    output logic [DW-1:0]        pc_q,
    output logic                 pc_load_q,
    output logic                 link_q
);

    localparam logic [DW-1:0] ST_WM = DW'(STATUS_MASK);
    localparam logic [DW-1:0] CA_WM = DW'(CAUSE_MASK);
    localparam logic [DW-1:0] EB_FX = DW'(EBASE_FIXED);
    localparam logic [DW-1:0] EB_WM = DW'(EBASE_MASK);

    logic [DW-1:0]        status_d, cause_d, epc_d, errepc_d, depc_d, ebase_d, pc_d;
    logic [NUM_HWREG-1:0] hwrena_d;
    logic                 pc_load_d, link_d;

    always_comb begin
        status_d  = status_q;
        cause_d   = cause_q;
        epc_d     = epc_q;
        errepc_d  = errepc_q;
        depc_d    = depc_q;
        ebase_d   = ebase_q;
        hwrena_d  = hwrena_q;
        pc_d      = pc_q;
        pc_load_d = 1'b0;
        link_d    = link_q;
        case (op)
            OP_WRITE: begin
                case (sel)
                    SEL_STATUS: status_d = (status_q & ~ST_WM) | (wdata & ST_WM);
                    SEL_CAUSE:  cause_d  = (cause_q & ~CA_WM) | (wdata & CA_WM);
                    SEL_EPC:    epc_d    = wdata;
                    SEL_ERREPC: errepc_d = wdata;
                    SEL_DEPC:   depc_d   = wdata;
                    SEL_EBASE:  ebase_d  = EB_FX | (wdata & EB_WM);
                    SEL_HWRENA: hwrena_d = wdata[NUM_HWREG-1:0];
                    default: ;
                endcase
            end
            OP_ERET: begin
                pc_load_d = 1'b1;
                link_d    = 1'b1;
                if (status_q[ST_ERL]) begin
                    pc_d             = errepc_q;
                    status_d[ST_ERL] = 1'b0;
                end else begin
                    pc_d             = epc_q;
                    status_d[ST_EXL] = 1'b0;
                end
            end
            OP_DERET: begin
                pc_load_d = 1'b1;
                link_d    = 1'b1;
                pc_d      = depc_q;
            end
            OP_DI: status_d[ST_IE] = 1'b0;
            OP_EI: status_d[ST_IE] = 1'b1;
            default: ;
        endcase
        if (ec_clear) begin
            cause_d[CA_EC_LO +: CA_EC_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= DW'(STATUS_RST);
            cause_q   <= '0;
            epc_q     <= '0;
            errepc_q  <= '0;
            depc_q    <= '0;
            ebase_q   <= EB_FX;
            hwrena_q  <= '0;
            pc_q      <= '0;
            pc_load_q <= 1'b0;
            link_q    <= 1'b0;
        end else begin
            status_q  <= status_d;
            cause_q   <= cause_d;
            epc_q     <= epc_d;
            errepc_q  <= errepc_d;
            depc_q    <= depc_d;
            ebase_q   <= ebase_d;
            hwrena_q  <= hwrena_d;
            pc_q      <= pc_d;
            pc_load_q <= pc_load_d;
            link_q    <= link_d;
        end
    end

    // R8
    cause_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && sel == SEL_CAUSE) |=>
        ((cause_q & ~CA_WM) == ($past(cause_q) & ~CA_WM)) ||
        ((cause_q & ~CA_WM & ~(DW'(31) << CA_EC_LO)) == ($past(cause_q) & ~CA_WM & ~(DW'(31) << CA_EC_LO))));

    // R9
    ebase_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ebase_q & ~EB_WM) == EB_FX));

    // R3
    eret_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ERET && !status_q[ST_ERL]) |=> (!status_q[ST_EXL] && pc_q == $past(epc_q)));

endmodule

// File: rtl/priv_irq_fsm.sv
`timescale 1ns/1ps
module priv_irq_fsm
    import priv_pkg::*;
#(
    parameter int PW = PEND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ie,
    input  logic          exl,
    input  logic          erl,
    input  logic          dbg,
    input  logic [PW-1:0] im,
    input  logic [PW-1:0] ip,
    output logic          irq_req,
    output logic          ec_clear
);

    irq_state_e state_q, state_d;
    logic       irq_cond;

    assign irq_cond = ie && !exl && !erl && !dbg && (|(im & ip));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:  if (irq_cond) state_d = IRQ_RAISE;
            IRQ_RAISE: state_d = irq_cond ? IRQ_WAIT : IRQ_IDLE;
            IRQ_WAIT:  if (!irq_cond) state_d = IRQ_IDLE;
            default:   state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_req  = 1'b0;
        ec_clear = 1'b0;
        unique case (state_q)
            IRQ_RAISE: begin
                irq_req  = 1'b1;
                ec_clear = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(irq_cond));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

endmodule

// File: rtl/priv_hwread.sv
`timescale 1ns/1ps
module priv_hwread #(
    parameter int DW         = 32,
    parameter int NUM_HWREG  = 4,
    parameter int SYNCI_STEP = 32,
    parameter int CC_RES     = 2,
    localparam int IDX_W     = $clog2(NUM_HWREG)
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 user_mode,
    input  logic                 cu0,
    input  logic [NUM_HWREG-1:0] hwrena,
    input  logic [9:0]           ebase_lo,
    input  logic [DW-1:0]        cycle_count,
    output logic                 allowed,
    output logic [DW-1:0]        value
);

    assign allowed = !user_mode || hwrena[idx] || cu0;

    always_comb begin
        case (idx)
            IDX_W'(0): value = DW'(ebase_lo);
            IDX_W'(1): value = DW'(SYNCI_STEP);
            IDX_W'(2): value = cycle_count;
            IDX_W'(3): value = DW'(CC_RES);
            default:   value = '0;
        endcase
    end

endmodule

// File: rtl/priv_state_ctrl.sv
`timescale 1ns/1ps
module priv_state_ctrl
    import priv_pkg::*;
#(
    parameter int DW         = 32,
    parameter int NUM_HWREG  = 4,
    parameter int SYNCI_STEP = 32,
    parameter int CC_RES     = 2,
    localparam int IDX_W     = $clog2(NUM_HWREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [2:0]       sel_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IDX_W-1:0] hw_idx_i,
    input  logic             debug_mode_i,
    input  logic [DW-1:0]    cycle_count_i,
    output logic [DW-1:0]    pc_o,
    output logic             pc_load_o,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o,
    output logic             user_mode_o,
    output logic             link_bit_o,
    output logic             irq_req_o,
    output logic             ri_exc_o
);

    op_e                  op;
    sel_e                 sel;
    logic [DW-1:0]        status_q, cause_q, epc_q, errepc_q, depc_q, ebase_q;
    logic [NUM_HWREG-1:0] hwrena_q;
    logic                 ec_clear;
    logic                 hw_ok;
    logic [DW-1:0]        hw_val;
    logic [DW-1:0]        reg_view;
    logic [DW-1:0]        rd_data_q;
    logic                 rd_valid_q, ri_q;

    assign op  = op_e'(op_i);
    assign sel = sel_e'(sel_i);

    priv_regs #(.DW(DW), .NUM_HWREG(NUM_HWREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .sel       (sel),
        .wdata     (wdata_i),
        .ec_clear  (ec_clear),
        .status_q  (status_q),
        .cause_q   (cause_q),
        .epc_q     (epc_q),
        .errepc_q  (errepc_q),
        .depc_q    (depc_q),
        .ebase_q   (ebase_q),
        .hwrena_q  (hwrena_q),
        .pc_q      (pc_o),
        .pc_load_q (pc_load_o),
        .link_q    (link_bit_o)
    );

    priv_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie       (status_q[ST_IE]),
        .exl      (status_q[ST_EXL]),
        .erl      (status_q[ST_ERL]),
        .dbg      (debug_mode_i),
        .im       (status_q[ST_IM_LO +: PEND_W]),
        .ip       (cause_q[CA_IP_LO +: PEND_W]),
        .irq_req  (irq_req_o),
        .ec_clear (ec_clear)
    );

    assign user_mode_o = !status_q[ST_EXL] && !status_q[ST_ERL] && !debug_mode_i && status_q[ST_UM];

    priv_hwread #(.DW(DW), .NUM_HWREG(NUM_HWREG), .SYNCI_STEP(SYNCI_STEP), .CC_RES(CC_RES)) u_hw (
        .idx         (hw_idx_i),
        .user_mode   (user_mode_o),
        .cu0         (status_q[ST_CU0]),
        .hwrena      (hwrena_q),
        .ebase_lo    (ebase_q[9:0]),
        .cycle_count (cycle_count_i),
        .allowed     (hw_ok),
        .value       (hw_val)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: reg_view = status_q;
            SEL_CAUSE:  reg_view = cause_q;
            SEL_EPC:    reg_view = epc_q;
            SEL_ERREPC: reg_view = errepc_q;
            SEL_DEPC:   reg_view = depc_q;
            SEL_EBASE:  reg_view = ebase_q;
            SEL_HWRENA: reg_view = DW'(hwrena_q);
            default:    reg_view = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            ri_q       <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            ri_q       <= 1'b0;
            case (op)
                OP_READ: begin
                    rd_data_q  <= reg_view;
                    rd_valid_q <= 1'b1;
                end
                OP_DI, OP_EI: begin
                    rd_data_q  <= status_q;
                    rd_valid_q <= 1'b1;
                end
                OP_RDHW: begin
                    if (hw_ok) begin
                        rd_data_q  <= hw_val;
                        rd_valid_q <= 1'b1;
                    end else begin
                        ri_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_data_o  = rd_data_q;
    assign rd_valid_o = rd_valid_q;
    assign ri_exc_o   = ri_q;

    // R2
    eret_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ERET && status_q[ST_ERL]) |=> (pc_o == $past(errepc_q) && !status_q[ST_ERL]));

    // R4
    deret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DERET) |=> (pc_o == $past(depc_q) && pc_load_o));

    // R5
    link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> link_bit_o);

    // R11
    ri_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_exc_o |-> ($past(user_mode_o) && !rd_valid_o));

    // R10
    di_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DI) |=> (!status_q[ST_IE] && rd_data_o == $past(status_q)));

endmodule

// File: tb/priv_state_ctrl_test.sv
`timescale 1ns/1ps
module priv_state_ctrl_test;

    localparam logic [2:0] NOP = 3'd0, WR = 3'd1, RD = 3'd2, ERET = 3'd3,
                           DERET = 3'd4, DI = 3'd5, EI = 3'd6, RDHW = 3'd7;
    localparam logic [2:0] S_ST = 3'd0, S_CA = 3'd1, S_EPC = 3'd2, S_ERR = 3'd3,
                           S_DEPC = 3'd4, S_EB = 3'd5, S_HWE = 3'd6;
    localparam logic [31:0] CC = 32'hC0FF_EE01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = NOP;
    logic [2:0]  sel_i = '0;
    logic [31:0] wdata_i = '0;
    logic [1:0]  hw_idx_i = '0;
    logic        debug_mode_i = 1'b0;
    logic [31:0] cycle_count_i = CC;
    logic [31:0] pc_o, rd_data_o;
    logic        pc_load_o, rd_valid_o, user_mode_o, link_bit_o, irq_req_o, ri_exc_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    priv_state_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i), .wdata_i(wdata_i),
        .hw_idx_i(hw_idx_i), .debug_mode_i(debug_mode_i), .cycle_count_i(cycle_count_i),
        .pc_o(pc_o), .pc_load_o(pc_load_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .user_mode_o(user_mode_o), .link_bit_o(link_bit_o), .irq_req_o(irq_req_o),
        .ri_exc_o(ri_exc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [2:0] o, input logic [2:0] s, input logic [31:0] d,
                        input logic [1:0] k);
        op_i = o; sel_i = s; wdata_i = d; hw_idx_i = k;
        @(negedge clk);
        op_i = NOP;
    endtask

    task automatic rd_reg(input logic [2:0] s, input string req, input logic [31:0] exp);
        step(RD, s, 32'h0, 2'd0);
        chk(req, {31'h0, rd_valid_o}, 32'h1);
        chk(req, rd_data_o, exp);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 user", {31'h0, user_mode_o}, 32'h0);
        chk("R1 link", {31'h0, link_bit_o}, 32'h0);
        chk("R1 irq", {31'h0, irq_req_o}, 32'h0);
        chk("R1 pcload", {31'h0, pc_load_o}, 32'h0);
        rd_reg(S_ST, "R1 status", 32'h0000_0004);
        rd_reg(S_CA, "R1 cause", 32'h0);
        rd_reg(S_EPC, "R1 epc", 32'h0);
        rd_reg(S_ERR, "R1 errepc", 32'h0);
        rd_reg(S_DEPC, "R1 depc", 32'h0);
        rd_reg(S_EB, "R1 ebase", 32'h8000_0000);
        rd_reg(S_HWE, "R1 hwrena", 32'h0);

        // R13 status mask
        step(WR, S_ST, 32'hFFFF_FFFF, 2'd0);
        rd_reg(S_ST, "R13 ones", 32'h1000_FF17);
        step(WR, S_ST, 32'h0, 2'd0);
        rd_reg(S_ST, "R13 zeros", 32'h0);

        // R8 cause mask
        step(WR, S_CA, 32'hFFFF_FFFF, 2'd0);
        rd_reg(S_CA, "R8 ones", 32'h00C0_0300);
        step(WR, S_CA, 32'h0, 2'd0);
        rd_reg(S_CA, "R8 zeros", 32'h0);

        // R9 ebase and hwrena format
        step(WR, S_EB, 32'hFFFF_FFFF, 2'd0);
        rd_reg(S_EB, "R9 ebase ones", 32'hBFFF_F000);
        step(WR, S_EB, 32'h1234_5678, 2'd0);
        rd_reg(S_EB, "R9 ebase pat", 32'h9234_5000);
        step(WR, S_HWE, 32'hFFFF_FFF5, 2'd0);
        rd_reg(S_HWE, "R9 hwrena", 32'h5);

        // R2 R3 R4 R5 returns
        step(WR, S_ERR, 32'h1111_0000, 2'd0);
        step(WR, S_EPC, 32'h2222_0000, 2'd0);
        step(WR, S_DEPC, 32'h3333_0000, 2'd0);
        step(WR, S_ST, 32'h0000_0006, 2'd0);
        chk("R5 link before", {31'h0, link_bit_o}, 32'h0);
        step(ERET, 3'd0, 32'h0, 2'd0);
        chk("R2 pc", pc_o, 32'h1111_0000);
        chk("R5 pcload", {31'h0, pc_load_o}, 32'h1);
        chk("R5 link", {31'h0, link_bit_o}, 32'h1);
        rd_reg(S_ST, "R2 status", 32'h0000_0002);
        chk("R5 pcload drop", {31'h0, pc_load_o}, 32'h0);
        step(ERET, 3'd0, 32'h0, 2'd0);
        chk("R3 pc", pc_o, 32'h2222_0000);
        chk("R3 pcload", {31'h0, pc_load_o}, 32'h1);
        rd_reg(S_ST, "R3 status", 32'h0);
        step(WR, S_ST, 32'h0000_0012, 2'd0);
        step(DERET, 3'd0, 32'h0, 2'd0);
        chk("R4 pc", pc_o, 32'h3333_0000);
        chk("R4 pcload", {31'h0, pc_load_o}, 32'h1);
        chk("R5 link deret", {31'h0, link_bit_o}, 32'h1);
        rd_reg(S_ST, "R4 status", 32'h0000_0012);

        // R10 interrupt disable / enable
        step(WR, S_ST, 32'h0000_0011, 2'd0);
        step(DI, 3'd0, 32'h0, 2'd0);
        chk("R10 di old", rd_data_o, 32'h0000_0011);
        rd_reg(S_ST, "R10 di new", 32'h0000_0010);
        step(EI, 3'd0, 32'h0, 2'd0);
        chk("R10 ei old", rd_data_o, 32'h0000_0010);
        rd_reg(S_ST, "R10 ei new", 32'h0000_0011);

        // R6 R11 R12 permission sweep
        step(WR, S_EB, 32'h0, 2'd0);
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int en = 0; en < 16; en++) begin
                    logic exl, erl, um, cu0, usr;
                    exl = s[0]; erl = s[1]; um = s[2]; cu0 = s[3];
                    debug_mode_i = d[0];
                    step(WR, S_ST, {3'b0, cu0, 23'h0, um, 1'b0, erl, exl, 1'b0}, 2'd0);
                    step(WR, S_HWE, 32'(en), 2'd0);
                    usr = !exl && !erl && !d[0] && um;
                    chk("R6 user", {31'h0, user_mode_o}, {31'h0, usr});
                    for (int k = 0; k < 4; k++) begin
                        logic ok;
                        logic [31:0] ev;
                        ok = !usr || en[k] || cu0;
                        ev = (k == 0) ? 32'h0 : (k == 1) ? 32'd32 : (k == 2) ? CC : 32'd2;
                        step(RDHW, 3'd0, 32'h0, 2'(k));
                        chk("R11 flags", {30'h0, rd_valid_o, ri_exc_o}, {30'h0, ok, !ok});
                        if (ok) chk("R12 value", rd_data_o, ev);
                    end
                end
            end
        end
        debug_mode_i = 1'b0;

        // R7 interrupt decision sweep
        for (int c = 0; c < 256; c++) begin
            logic ie, exl, erl, dbg, exp_irq;
            logic [1:0] im, ip;
            ie = c[0]; exl = c[1]; erl = c[2]; dbg = c[3]; im = c[5:4]; ip = c[7:6];
            step(WR, S_CA, 32'h0, 2'd0);
            step(NOP, 3'd0, 32'h0, 2'd0);
            debug_mode_i = dbg;
            step(WR, S_ST, {22'h0, im, 5'h0, erl, exl, ie}, 2'd0);
            step(WR, S_CA, {22'h0, ip, 8'h0}, 2'd0);
            exp_irq = ie && !exl && !erl && !dbg && (|(im & ip));
            step(NOP, 3'd0, 32'h0, 2'd0);
            chk("R7 raise", {31'h0, irq_req_o}, {31'h0, exp_irq});
            step(NOP, 3'd0, 32'h0, 2'd0);
            chk("R7 pulse", {31'h0, irq_req_o}, 32'h0);
        end
        debug_mode_i = 1'b0;
        rd_reg(S_CA, "R7 cause ec", 32'h0000_0300);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule